// File: doc/BRIEF.md
# Quadrature Position Counter

This block turns the two phase signals of an incremental rotary or linear encoder, plus its once-per-turn index pulse, into a position count and a direction flag. It counts at four times the line rate, so every transition of either phase moves the count by one step. The phase, index and configuration inputs are assumed to arrive already synchronized to the block clock and free of glitches.

Software programs it through a small write-only register port. One register holds enable, phase swap, count mode and index gating. One holds the ceiling. One holds the interrupt mask. The last is a write-one-to-clear port for the sticky event flags. There are two count modes. In ceiling mode the count wraps between zero and a programmed ceiling. In index mode a qualified index pulse returns the count to zero. While the block is enabled its configuration is frozen, so a running count never sees a ceiling or mode change. The event flags drive one level interrupt through a per-bit mask.

Top module: `qdec_position_counter`

## Requirements
- R1: After reset the count is 0, direction is 1 (up), all status bits are 0, the interrupt is low, the block is disabled, the ceiling is 0, the mask is 0 and the mode is index mode.
- R2: While enabled, each edge of phase A or phase B (only one of them changing in a cycle) moves the count by exactly one, one cycle after the input changes. The (A,B) sequence 00→10→11→01→00 (A leads B) counts up and sets direction to 1. The reverse sequence counts down and sets direction to 0.
- R3: Control bit 1 (swap) exchanges the roles of A and B, so the sequence that counted up now counts down.
- R4: With control bit 2 set (ceiling mode), an up step from a count at or above the ceiling (register address 1) gives 0 and sets status bit 0. A down step from 0 gives the ceiling and sets status bit 1.
- R5: With control bit 2 clear (index mode), a rising edge of the index input resets the count to 0 when the pin levels match gate field bits [4:3]: 0 needs A=0,B=0; 1 needs A=0,B=1; 2 needs A=1,B0; 3 needs A=1,B=1. The index reset takes priority over a step in the same cycle. It sets status bit 0 if the direction after that cycle is up and status bit 1 if it is down. An index pulse at other levels leaves the count unchanged. Outside index resets the count wraps modulo 2^CNT_W and sets no flag.
- R6: In ceiling mode the index input has no effect on the count.
- R7: While enabled, a cycle in which A and B both change leaves the count unchanged and sets status bit 3.
- R8: A step whose direction differs from the current direction output sets status bit 2.
- R9: While control bit 0 (enable) is set, writes to the ceiling are ignored, and a control write changes only the enable bit. Mask and status writes still act.
- R10: While disabled the count and direction hold, whatever the phase inputs do.
- R11: Writing to address 3 clears every status bit whose data bit is 1. Other status bits are unchanged.
- R12: The interrupt output is high exactly when some status bit is set whose mask bit (address 2, 1 = pass) is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| qa_i | input | 1 | Phase A, synchronized and filtered |
| qb_i | input | 1 | Phase B, synchronized and filtered |
| qidx_i | input | 1 | Index pulse, synchronized and filtered |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register select: 0 control, 1 ceiling, 2 mask, 3 status clear |
| cfg_wdata_i | input | CNT_W | Register write data |
| count_o | output | CNT_W | Position count |
| dir_o | output | 1 | Direction of the last step, 1 = up |
| status_o | output | 4 | Sticky flags: 0 wrap up, 1 wrap down, 2 direction change, 3 phase error |
| irq_o | output | 1 | Masked OR of the status flags |

## Verification
The bench builds the block with CNT_W set to 16. The modular wrap of index mode then lands on 16'hFFFF after one down step, and the full-width roll is checked directly. The ceiling is a register and not a parameter, so small values such as 3 and 10 bring both ceiling wraps within four edges. The same small values also make the locked-ceiling case visible: a ceiling write while enabled would change where the wrap lands.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  localparam int ST_W       = 4;
  localparam int ST_WRAP_UP = 0;
  localparam int ST_WRAP_DN = 1;
  localparam int ST_DIR_CHG = 2;
  localparam int ST_PH_ERR  = 3;
  localparam int CTRL_W     = 5;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CEIL = 2'd1,
    REG_MASK = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  // Control word layout: [4:3] gate, [2] ceiling mode, [1] swap, [0] enable
  typedef struct packed {
    logic [1:0] gate;
    logic       roll;
    logic       swap;
    logic       en;
  } ctrl_t;

endpackage

// File: rtl/qdec_cfg_regs.sv
module qdec_cfg_regs
  import qdec_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [1:0]          addr,
  input  logic [CNT_W-1:0]    wdata,
  output ctrl_t               ctrl,
  output logic [CNT_W-1:0]    ceil,
  output logic [ST_W-1:0]     mask,
  output logic [ST_W-1:0]     stat_clr
);

  ctrl_t             ctrl_q, ctrl_n;
  logic [CNT_W-1:0]  ceil_q, ceil_n;
  logic [ST_W-1:0]   mask_q, mask_n;

  always_comb begin
    ctrl_n   = ctrl_q;
    ceil_n   = ceil_q;
    mask_n   = mask_q;
    stat_clr = '0;
    if (wr) begin
      case (reg_sel_e'(addr))
        REG_CTRL: begin
          if (ctrl_q.en) ctrl_n.en = wdata[0];
          else           ctrl_n    = ctrl_t'(wdata[CTRL_W-1:0]);
        end
        REG_CEIL: if (!ctrl_q.en) ceil_n = wdata;
        REG_MASK: mask_n   = wdata[ST_W-1:0];
        REG_STAT: stat_clr = wdata[ST_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ceil_q <= '0;
      mask_q <= '0;
    end else if (wr) begin
      ctrl_q <= ctrl_n;
      ceil_q <= ceil_n;
      mask_q <= mask_n;
    end
  end

  assign ctrl = ctrl_q;
  assign ceil = ceil_q;
  assign mask = mask_q;

endmodule

// File: rtl/qdec_phase_decoder.sv
module qdec_phase_decoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_a,
  input  logic       pin_b,
  input  logic       pin_idx,
  input  logic       swap,
  input  logic [1:0] gate,
  output logic       step_up,
  output logic       step_dn,
  output logic       phase_err,
  output logic       idx_evt
);

  logic pa_q, pb_q, qual_q;
  logic a_cur, b_cur, a_prv, b_prv;
  logic da, db, qual;

  // Raw pins are stored; swap is applied to both sides of the compare
  assign a_cur = swap ? pin_b : pin_a;
  assign b_cur = swap ? pin_a : pin_b;
  assign a_prv = swap ? pb_q  : pa_q;
  assign b_prv = swap ? pa_q  : pb_q;

  assign da        = a_cur ^ a_prv;
  assign db        = b_cur ^ b_prv;
  assign phase_err = da & db;
  assign step_up   = (da ^ db) & (a_cur ^ b_prv);
  assign step_dn   = (da ^ db) & ~(a_cur ^ b_prv);

  assign qual    = pin_idx & (pin_a == gate[1]) & (pin_b == gate[0]);
  assign idx_evt = qual & ~qual_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q   <= 1'b0;
      pb_q   <= 1'b0;
      qual_q <= 1'b0;
    end else begin
      pa_q   <= pin_a;
      pb_q   <= pin_b;
      qual_q <= qual;
    end
  end

endmodule

// File: rtl/qdec_pos_counter.sv
module qdec_pos_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             roll,
  input  logic [CNT_W-1:0] ceil,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             idx_evt,
  output logic [CNT_W-1:0] count,
  output logic             dir,
  output logic             wrap_up,
  output logic             wrap_dn,
  output logic             dir_chg
);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             dir_q, dir_n;

  always_comb begin
    cnt_n   = cnt_q;
    dir_n   = dir_q;
    wrap_up = 1'b0;
    wrap_dn = 1'b0;
    if (step_up)      dir_n = 1'b1;
    else if (step_dn) dir_n = 1'b0;

    if (!roll && idx_evt) begin
      cnt_n   = '0;
      wrap_up = dir_n;
      wrap_dn = ~dir_n;
    end else if (step_up) begin
      if (roll && (cnt_q >= ceil)) begin
        cnt_n   = '0;
        wrap_up = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end else if (step_dn) begin
      if (roll && (cnt_q == '0)) begin
        cnt_n   = ceil;
        wrap_dn = 1'b1;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end

    if (!en) begin
      cnt_n   = cnt_q;
      dir_n   = dir_q;
      wrap_up = 1'b0;
      wrap_dn = 1'b0;
    end
  end

  assign dir_chg = dir_n ^ dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else if (en) begin
      cnt_q <= cnt_n;
      dir_q <= dir_n;
    end
  end

  assign count = cnt_q;
  assign dir   = dir_q;

endmodule

// File: rtl/qdec_irq_status.sv
module qdec_irq_status
  import qdec_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] set,
  input  logic [ST_W-1:0] clr,
  input  logic [ST_W-1:0] mask,
  output logic [ST_W-1:0] status,
  output logic            irq
);

  logic [ST_W-1:0] st_q, st_n;
  logic            upd;

  assign upd  = (|set) | (|clr);
  assign st_n = (st_q & ~clr) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= '0;
    else if (upd) st_q <= st_n;
  end

  assign status = st_q;
  assign irq    = |(st_q & mask);

endmodule

// File: rtl/qdec_position_counter.sv
module qdec_position_counter
  import qdec_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qa_i,
  input  logic             qb_i,
  input  logic             qidx_i,
  input  logic             cfg_wr_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [CNT_W-1:0] cfg_wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_o,
  output logic [ST_W-1:0]  status_o,
  output logic             irq_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  ctrl_t            ctrl;
  logic             en_w, roll_w;
  logic [CNT_W-1:0] ceil_w;
  logic [ST_W-1:0]  mask_w, clr_w, set_w;
  logic             step_up_w, step_dn_w, phase_err_w, idx_evt_w;
  logic             wrap_up_w, wrap_dn_w, dir_chg_w;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  qdec_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr       (cfg_wr_i),
    .addr     (cfg_addr_i),
    .wdata    (cfg_wdata_i),
    .ctrl     (ctrl),
    .ceil     (ceil_w),
    .mask     (mask_w),
    .stat_clr (clr_w)
  );

  assign en_w   = ctrl.en;
  assign roll_w = ctrl.roll;

  qdec_phase_decoder u_dec (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pin_a     (qa_i),
    .pin_b     (qb_i),
    .pin_idx   (qidx_i),
    .swap      (ctrl.swap),
    .gate      (ctrl.gate),
    .step_up   (step_up_w),
    .step_dn   (step_dn_w),
    .phase_err (phase_err_w),
    .idx_evt   (idx_evt_w)
  );

  qdec_pos_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en      (en_w),
    .roll    (roll_w),
    .ceil    (ceil_w),
    .step_up (step_up_w),
    .step_dn (step_dn_w),
    .idx_evt (idx_evt_w),
    .count   (count_o),
    .dir     (dir_o),
    .wrap_up (wrap_up_w),
    .wrap_dn (wrap_dn_w),
    .dir_chg (dir_chg_w)
  );

  always_comb begin
    set_w             = '0;
    set_w[ST_WRAP_UP] = wrap_up_w;
    set_w[ST_WRAP_DN] = wrap_dn_w;
    set_w[ST_DIR_CHG] = dir_chg_w;
    set_w[ST_PH_ERR]  = phase_err_w & en_w;
  end

  qdec_irq_status u_st (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .set    (set_w),
    .clr    (clr_w),
    .mask   (mask_w),
    .status (status_o),
    .irq    (irq_o)
  );

endmodule

// File: rtl/qdec_position_counter_chk.sv
module qdec_position_counter_chk
  import qdec_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             roll,
  input logic [CNT_W-1:0] ceil,
  input logic [ST_W-1:0]  mask,
  input logic             step_up,
  input logic             step_dn,
  input logic             phase_err,
  input logic             idx_evt,
  input logic [CNT_W-1:0] count,
  input logic [ST_W-1:0]  status,
  input logic             irq
);

  assert_hold_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count));

  assert_wrap_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && roll && step_up && count == ceil) |=> (count == '0 && status[ST_WRAP_UP]));

  assert_wrap_dn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && roll && step_dn && count == '0) |=> (count == $past(ceil) && status[ST_WRAP_DN]));

  assert_index_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !roll && idx_evt) |=> (count == '0));

  assert_phase_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && phase_err) |=> ($stable(count) && status[ST_PH_ERR]));

  assert_ceil_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(ceil));

  assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

endmodule

bind qdec_position_counter qdec_position_counter_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .en        (en_w),
  .roll      (roll_w),
  .ceil      (ceil_w),
  .mask      (mask_w),
  .step_up   (step_up_w),
  .step_dn   (step_dn_w),
  .phase_err (phase_err_w),
  .idx_evt   (idx_evt_w),
  .count     (count_o),
  .status    (status_o),
  .irq       (irq_o)
);

// File: tb/qdec_position_counter_tb_top.sv
module qdec_position_counter_tb_top;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             qa, qb, qi;
  logic             wr;
  logic [1:0]       addr;
  logic [CNT_W-1:0] wdata;
  logic [CNT_W-1:0] count;
  logic             dir;
  logic [3:0]       status;
  logic             irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  qdec_position_counter #(.CNT_W(CNT_W)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .qa_i        (qa),
    .qb_i        (qb),
    .qidx_i      (qi),
    .cfg_wr_i    (wr),
    .cfg_addr_i  (addr),
    .cfg_wdata_i (wdata),
    .count_o     (count),
    .dir_o       (dir),
    .status_o    (status),
    .irq_o       (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; qa = 1'b0; qb = 1'b0; qi = 1'b0;
    wr = 1'b0; addr = 2'd0; wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [CNT_W-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic pins(input logic a, input logic b);
    @(negedge clk);
    qa = a; qb = b;
    @(negedge clk);
  endtask

  task automatic pulse_idx();
    @(negedge clk);
    qi = 1'b1;
    @(negedge clk);
    qi = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 count", count, 0);
    chk("R1 dir", dir, 1);
    chk("R1 status", status, 0);
    chk("R1 irq", irq, 0);
    pins(1, 0);
    chk("R1 disabled after reset", count, 0);
  endtask

  task automatic t_x4();
    do_reset();
    wr_reg(0, 16'h0001);
    pins(1, 0); chk("R2 up step 1", count, 1);
    pins(1, 1); chk("R2 up step 2", count, 2);
    pins(0, 1); chk("R2 up step 3", count, 3);
    pins(0, 0); chk("R2 up step 4", count, 4);
    chk("R2 dir up", dir, 1);
    chk("R8 no dir change yet", status, 0);
    pins(0, 1); chk("R2 down step", count, 3);
    chk("R2 dir down", dir, 0);
    chk("R8 dir change flag", status, 4'b0100);
    pins(1, 1); pins(1, 0); pins(0, 0);
    chk("R2 back to zero", count, 0);
    wr_reg(3, 16'h0004);
    chk("R11 clear dir flag", status, 0);
  endtask

  task automatic t_swap();
    do_reset();
    wr_reg(0, 16'h0003);
    pins(1, 0);
    chk("R3 swapped counts down, R5 modular wrap", count, 16'hFFFF);
    chk("R3 dir", dir, 0);
    chk("R5 no flag on modular wrap", status, 4'b0100);
    pins(1, 1);
    chk("R3 second swapped step", count, 16'hFFFE);
  endtask

  task automatic t_roll();
    do_reset();
    wr_reg(1, 16'd3);
    wr_reg(0, 16'h000D);  // gate 1, ceiling mode, enabled
    pins(1, 0); pins(1, 1); pins(0, 1);
    chk("R4 reach ceiling", count, 3);
    pins(0, 0);
    chk("R4 up wrap to zero", count, 0);
    chk("R4 wrap up flag", status, 4'b0001);
    pins(0, 1);
    chk("R4 down wrap to ceiling", count, 3);
    chk("R4 wrap down flag", status, 4'b0111);
    pulse_idx();
    chk("R6 index ignored in ceiling mode", count, 3);
    wr_reg(3, 16'h000F);
    chk("R11 clear all", status, 0);
    wr_reg(1, 16'd10);
    wr_reg(0, 16'h0001);
    pins(0, 0);
    chk("R9 ceiling and mode kept while enabled", count, 0);
    chk("R9 wrap flag with old ceiling", status, 4'b0101);
    wr_reg(0, 16'h0000);
    pins(1, 0);
    chk("R10 held while disabled", count, 0);
    chk("R10 status untouched while disabled", status, 4'b0101);
    wr_reg(1, 16'd10);
    wr_reg(0, 16'h0005);
    pins(0, 0);
    chk("R9 ceiling written when disabled", count, 10);
  endtask

  task automatic t_index();
    do_reset();
    wr_reg(0, 16'h0011);  // gate 2 (A=1,B=0), index mode, enabled
    pins(1, 0); chk("R5 step before index", count, 1);
    pulse_idx();
    chk("R5 qualified index resets", count, 0);
    chk("R5 reset while up flag", status, 4'b0001);
    wr_reg(3, 16'h000F);
    pins(1, 1); pins(0, 1); pins(0, 0); pins(1, 0); pins(1, 1);
    chk("R5 count before gated pulse", count, 5);
    pulse_idx();
    chk("R5 index at wrong levels ignored", count, 5);
    pins(1, 0);
    chk("R5 down into gate level", count, 4);
    pulse_idx();
    chk("R5 index resets while down", count, 0);
    chk("R5 reset while down flag", status, 4'b0110);
  endtask

  task automatic t_phase_irq();
    do_reset();
    wr_reg(0, 16'h0001);
    pins(1, 1);
    chk("R7 count unchanged on phase error", count, 0);
    chk("R7 phase error flag", status, 4'b1000);
    chk("R12 masked irq low", irq, 0);
    wr_reg(2, 16'h0008);
    chk("R12 unmasked irq high", irq, 1);
    wr_reg(2, 16'h0004);
    chk("R12 other bit unmasked irq low", irq, 0);
    wr_reg(2, 16'h0008);
    wr_reg(3, 16'h0008);
    chk("R11 phase flag cleared", status, 0);
    chk("R12 irq low after clear", irq, 0);
  endtask

  initial begin
    t_reset();
    t_x4();
    t_swap();
    t_roll();
    t_index();
    t_phase_irq();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule